// File: doc/BRIEF.md
# Real-time-clock domain clock control register

This block is the single control and status word that governs clocking of a battery-backed real-time-clock domain. Software writes it through a plain synchronous write port and reads it back with zero latency. It holds the two-bit clock source select for the real-time clock, the real-time-clock enable, a software domain reset, the enable and failure flag of a crystal clock-security monitor, and the enable and source choice for a low-speed clock output.

Several fields follow hardware-enforced rules rather than plain read/write behaviour. Once a source has been chosen, the select field cannot be rewritten. It reopens only through a domain reset, or while a crystal failure is flagged. Setting the security monitor requires a running, ready crystal and a chosen source. After that the monitor cannot be switched off until a failure has been seen. The failure flag is set only by hardware and stays set until the domain reset.

The decoded source lines and the enables leave the block as level outputs for the clock multiplexers and gates placed around it.

Top module: `rtc_dom_clkctl`

## Requirements
- R1: While the power-on reset (rst_n low) is active, and right after it, every field is 0 and rdata reads 0.
- R2: The source select sits at rdata[9:8] and is encoded 0 = none, 1 = external crystal, 2 = internal RC, 3 = high-speed clock divided by 32. src_onehot has exactly the bit set whose index equals that code.
- R3: While the select is non-zero and the failure flag is 0, writes to bits 9:8 leave the select unchanged.
- R4: While the select is 0, or while the failure flag (bit 6) is 1, a write loads bits 9:8 into the select on the next clock.
- R5: A write with bit 16 set clears the select, the real-time-clock enable (bit 15), the security enable (bit 5), the failure flag (bit 6) and both output fields (bits 24, 25) on the next clock, and stores bit 16 as 1. dom_rst follows the stored bit 16, and a later write with bit 16 = 0 clears it.
- R6: A write with bit 5 = 1 sets the security enable only if xtal_en and xtal_rdy are both 1 and the select is already non-zero in that cycle. Otherwise bit 5 stays 0.
- R7: A write with bit 5 = 0 clears the security enable only while the failure flag is 1. While the flag is 0 the enable stays 1.
- R8: The failure flag is set on the clock after a one-cycle xtal_fail_pulse that arrives while the security enable is 1. A pulse while the enable is 0 has no effect. Writes to bit 6 have no effect. The flag stays set until a domain reset.
- R9: Bits 15 (real-time-clock enable), 24 (low-speed output enable) and 25 (output source, 0 = internal RC, 1 = crystal) take the written value on the next clock. They drive rtc_clk_en, lso_en and lso_sel_xtal.
- R10: Bits 31:26, 23:17, 14:10 and 7 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe for the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current register value, combinational |
| xtal_en | input | 1 | External crystal oscillator is switched on |
| xtal_rdy | input | 1 | External crystal oscillator is stable |
| xtal_fail_pulse | input | 1 | One-cycle crystal failure indication from the monitor |
| src_onehot | output | 4 | Decoded source select: none, crystal, RC, divided high-speed |
| rtc_clk_en | output | 1 | Clock enable for the real-time clock and tamper logic |
| css_en | output | 1 | Crystal security monitor enable |
| lso_en | output | 1 | Low-speed clock output enable |
| lso_sel_xtal | output | 1 | Low-speed output source, 1 = crystal |
| dom_rst | output | 1 | Software domain reset level |

## Verification
The hardest state to reach is a locked select that reopens. That takes a chosen source, a security enable accepted under the correct crystal conditions, and then a failure pulse that lands while the enable is set. Directed steps build that chain in order. Between the steps they try each gating input alone, so that every rejected write is seen not to change the state. A long pseudo-random phase follows. It keeps domain resets rare and failure pulses occasional, so the lock, the sticky enable and the flag interact in many orders. After every clock a behavioural model checks the read value and all outputs.

// File: rtl/rtcdc_pkg.sv
package rtcdc_pkg;

    localparam int REG_W      = 32;
    localparam int SEL_W      = 2;
    localparam int SRC_N      = 1 << SEL_W;

    localparam int POS_SEL_LO = 8;
    localparam int POS_SEL_HI = POS_SEL_LO + SEL_W - 1;
    localparam int POS_FAIL   = 6;
    localparam int POS_CSS    = 5;
    localparam int POS_RTCEN  = 15;
    localparam int POS_DRST   = 16;
    localparam int POS_LSOEN  = 24;
    localparam int POS_LSOSEL = 25;

    localparam logic [REG_W-1:0] RSVD_MASK = 32'hFCFE_7C80;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE  = 2'd0,
        SRC_XTAL  = 2'd1,
        SRC_RC    = 2'd2,
        SRC_HSDIV = 2'd3
    } src_e;

    typedef struct packed {
        logic drst;
        logic rtc_en;
        logic lso_en;
        logic lso_xtal;
    } ctl_t;

    typedef struct packed {
        logic css;
        logic fail;
    } sec_t;

endpackage

// File: rtl/rtcdc_srcsel.sv
module rtcdc_srcsel
    import rtcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic dom_clr,
    input  src_e wr_src,
    input  logic fail_q,
    output src_e src_q
);

    src_e src_d;
    logic open_w;

    // the field accepts a write while empty or after a crystal failure
    always_comb begin
        open_w = (src_q == SRC_NONE) || fail_q;
        src_d  = src_q;
        if (dom_clr) begin
            src_d = SRC_NONE;
        end else if (wr_en && open_w) begin
            src_d = wr_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
        end else begin
            src_q <= src_d;
        end
    end

    assert_sel_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q != SRC_NONE && !fail_q && !dom_clr) |=> (src_q == $past(src_q)));

    assert_sel_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dom_clr && (src_q == SRC_NONE || fail_q)) |=> (src_q == $past(wr_src)));

    assert_sel_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dom_clr |=> (src_q == SRC_NONE));

endmodule

// File: rtl/rtcdc_css.sv
module rtcdc_css
    import rtcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic dom_clr,
    input  logic wr_css,
    input  logic xtal_en,
    input  logic xtal_rdy,
    input  logic src_chosen,
    input  logic fail_pulse,
    output logic css_q,
    output logic fail_q
);

    sec_t sec_d, sec_q;
    logic arm_ok;

    always_comb begin
        arm_ok = xtal_en && xtal_rdy && src_chosen;
        sec_d  = sec_q;
        if (dom_clr) begin
            sec_d = '0;
        end else begin
            if (fail_pulse && sec_q.css) begin
                sec_d.fail = 1'b1;
            end
            if (wr_en) begin
                if (wr_css && !sec_q.css && arm_ok) begin
                    sec_d.css = 1'b1;
                end else if (!wr_css && sec_q.css && sec_q.fail) begin
                    sec_d.css = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign css_q  = sec_q.css;
    assign fail_q = sec_q.fail;

    assert_css_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(css_q) |-> $past(wr_en && wr_css && xtal_en && xtal_rdy && src_chosen));

    assert_css_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (css_q && !fail_q && !dom_clr) |=> css_q);

    assert_fail_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> $past(fail_pulse && css_q));

    assert_fail_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !dom_clr) |=> fail_q);

endmodule

// File: rtl/rtcdc_rdmux.sv
module rtcdc_rdmux
    import rtcdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  src_e             src_q,
    input  logic             css_q,
    input  logic             fail_q,
    input  ctl_t             ctl_q,
    output logic [REG_W-1:0] rdata,
    output logic [SRC_N-1:0] src_onehot
);

    always_comb begin
        rdata                        = '0;
        rdata[POS_SEL_HI:POS_SEL_LO] = src_q;
        rdata[POS_FAIL]              = fail_q;
        rdata[POS_CSS]               = css_q;
        rdata[POS_RTCEN]             = ctl_q.rtc_en;
        rdata[POS_DRST]              = ctl_q.drst;
        rdata[POS_LSOEN]             = ctl_q.lso_en;
        rdata[POS_LSOSEL]            = ctl_q.lso_xtal;
    end

    for (genvar gi = 0; gi < SRC_N; gi++) begin : g_dec
        assign src_onehot[gi] = (src_q == src_e'(gi));
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_onehot) == 1 && src_onehot[rdata[POS_SEL_HI:POS_SEL_LO]]);

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & RSVD_MASK) == '0);

endmodule

// File: rtl/rtc_dom_clkctl.sv
module rtc_dom_clkctl
    import rtcdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        xtal_en,
    input  logic        xtal_rdy,
    input  logic        xtal_fail_pulse,
    output logic [3:0]  src_onehot,
    output logic        rtc_clk_en,
    output logic        css_en,
    output logic        lso_en,
    output logic        lso_sel_xtal,
    output logic        dom_rst
);

    ctl_t ctl_d, ctl_q;
    src_e src_q;
    logic css_q, fail_q;
    logic dom_clr;
    logic rsvd_unused;

    assign dom_clr     = wr_en && wdata[POS_DRST];
    assign rsvd_unused = ^(wdata & RSVD_MASK) ^ wdata[POS_FAIL];

    always_comb begin
        ctl_d = ctl_q;
        if (dom_clr) begin
            ctl_d      = '0;
            ctl_d.drst = 1'b1;
        end else if (wr_en) begin
            ctl_d.drst     = 1'b0;
            ctl_d.rtc_en   = wdata[POS_RTCEN];
            ctl_d.lso_en   = wdata[POS_LSOEN];
            ctl_d.lso_xtal = wdata[POS_LSOSEL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rtcdc_srcsel u_srcsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .dom_clr (dom_clr),
        .wr_src  (src_e'(wdata[POS_SEL_HI:POS_SEL_LO])),
        .fail_q  (fail_q),
        .src_q   (src_q)
    );

    rtcdc_css u_css (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .dom_clr    (dom_clr),
        .wr_css     (wdata[POS_CSS]),
        .xtal_en    (xtal_en),
        .xtal_rdy   (xtal_rdy),
        .src_chosen (src_q != SRC_NONE),
        .fail_pulse (xtal_fail_pulse),
        .css_q      (css_q),
        .fail_q     (fail_q)
    );

    rtcdc_rdmux u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_q      (src_q),
        .css_q      (css_q),
        .fail_q     (fail_q),
        .ctl_q      (ctl_q),
        .rdata      (rdata),
        .src_onehot (src_onehot)
    );

    assign rtc_clk_en   = ctl_q.rtc_en;
    assign css_en       = css_q;
    assign lso_en       = ctl_q.lso_en;
    assign lso_sel_xtal = ctl_q.lso_xtal;
    assign dom_rst      = ctl_q.drst;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (rdata == '0));

    assert_domain_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dom_clr |=> (dom_rst && !rtc_clk_en && !css_en && !lso_en && !lso_sel_xtal
                     && rdata[POS_FAIL] == 1'b0));

    assert_plain_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dom_clr) |=> (rtc_clk_en == $past(wdata[POS_RTCEN])
                                 && lso_en == $past(wdata[POS_LSOEN])
                                 && lso_sel_xtal == $past(wdata[POS_LSOSEL])
                                 && !dom_rst));

endmodule

// File: tb/sim_rtc_dom_clkctl.sv
module sim_rtc_dom_clkctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        xtal_en = 1'b0;
    logic        xtal_rdy = 1'b0;
    logic        xtal_fail_pulse = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  src_onehot;
    logic        rtc_clk_en, css_en, lso_en, lso_sel_xtal, dom_rst;

    localparam logic [31:0] RSVD = 32'hFCFE_7C80;

    always #2 clk = ~clk;

    rtc_dom_clkctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .xtal_en(xtal_en), .xtal_rdy(xtal_rdy), .xtal_fail_pulse(xtal_fail_pulse),
        .src_onehot(src_onehot), .rtc_clk_en(rtc_clk_en), .css_en(css_en),
        .lso_en(lso_en), .lso_sel_xtal(lso_sel_xtal), .dom_rst(dom_rst)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural model state
    int m_sel = 0, m_rtc = 0, m_dr = 0, m_css = 0, m_fail = 0, m_lse = 0, m_lsel = 0;

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[9:8] = m_sel[1:0];
        w[6]   = m_fail[0];
        w[5]   = m_css[0];
        w[15]  = m_rtc[0];
        w[16]  = m_dr[0];
        w[24]  = m_lse[0];
        w[25]  = m_lsel[0];
        return w;
    endfunction

    task automatic check(input string tag);
        logic [31:0] ew = model_word();
        logic [8:0]  act = {src_onehot, rtc_clk_en, css_en, lso_en, lso_sel_xtal, dom_rst};
        logic [3:0]  eoh = 4'b0001 << m_sel;
        logic [8:0]  exp = {eoh, m_rtc[0], m_css[0], m_lse[0], m_lsel[0], m_dr[0]};
        checks++;
        if (rdata !== ew || act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h outs=%b expected rdata=%h outs=%b", tag, rdata, act, ew, exp);
        end
    endtask

    task automatic model_update(input bit we, input logic [31:0] d, input bit en, input bit rdy, input bit pf);
        int n_sel = m_sel, n_css = m_css, n_fail = m_fail;
        if (we && d[16]) begin
            m_sel = 0; m_css = 0; m_fail = 0; m_rtc = 0; m_lse = 0; m_lsel = 0; m_dr = 1;
            return;
        end
        if (pf && m_css == 1) n_fail = 1;
        if (we) begin
            if (m_sel == 0 || m_fail == 1) n_sel = int'(d[9:8]);
            if (d[5] && m_css == 0 && en && rdy && m_sel != 0) n_css = 1;
            if (!d[5] && m_css == 1 && m_fail == 1) n_css = 0;
            m_rtc = int'(d[15]); m_lse = int'(d[24]); m_lsel = int'(d[25]); m_dr = 0;
        end
        m_sel = n_sel; m_css = n_css; m_fail = n_fail;
    endtask

    task automatic step(input bit we, input logic [31:0] d, input bit en, input bit rdy,
                        input bit pf, input string tag);
        @(negedge clk);
        wr_en = we; wdata = d; xtal_en = en; xtal_rdy = rdy; xtal_fail_pulse = pf;
        @(posedge clk);
        model_update(we, d, en, rdy, pf);
        #1;
        check(tag);
        wr_en = 1'b0; xtal_fail_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset");

        step(1, 32'h0000_0100, 0, 0, 0, "R2 select crystal");
        step(1, 32'h0000_0200, 0, 0, 0, "R3 locked select");
        step(1, 32'h0000_0300 | RSVD, 0, 0, 0, "R10 reserved ignored");
        step(1, 32'h0300_8100, 0, 0, 0, "R9 plain bits");
        step(1, 32'h0000_8120, 0, 1, 0, "R6 no crystal enable");
        step(1, 32'h0000_8120, 1, 0, 0, "R6 crystal not ready");
        step(1, 32'h0000_8120, 1, 1, 0, "R6 enable accepted");
        step(1, 32'h0000_8100, 1, 1, 0, "R7 sticky without failure");
        step(1, 32'h0000_8160, 1, 1, 0, "R8 flag not writable");
        step(0, 32'h0,         1, 1, 1, "R8 failure sets flag");
        step(0, 32'h0,         1, 1, 0, "R8 flag holds");
        step(1, 32'h0000_8220, 1, 1, 0, "R4 select reopened");
        step(1, 32'h0000_8300, 1, 1, 0, "R7 enable cleared after failure");
        step(1, 32'h0000_8320, 1, 1, 1, "R3 select and enable with failure flag");
        step(1, 32'h0001_0000, 1, 1, 0, "R5 domain reset");
        step(1, 32'h0301_8320, 1, 1, 1, "R5 held in domain reset");
        step(1, 32'h0000_0000, 1, 1, 0, "R5 release");
        step(1, 32'h0000_0020, 1, 1, 0, "R6 no source chosen");
        step(1, 32'h0000_0320, 1, 1, 0, "R6 source chosen same write");
        step(0, 32'h0,         0, 0, 1, "R8 pulse ignored while disabled");
        step(1, 32'h0000_0020, 1, 1, 0, "R6 enable after select");
        step(1, 32'h0000_0120, 1, 1, 0, "R3 locked at three");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] d = $urandom;
            if (($urandom % 12) != 0) d[16] = 1'b0;
            step(($urandom % 3) != 0, d, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 ($urandom % 7) == 0, "R3 random mix");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule